// File: doc/BRIEF.md
# Stereo Serial Audio Slave Transmitter

This block sends a stream of stereo sample pairs over a three-wire serial audio link. It does not drive the bit clock or the word select line: both come from an external master. The block drives only the serial data line. SCK and WS are sampled into the system clock domain, and every action happens on detected SCK edges. This keeps all the logic synchronous to `clk`.

Sample pairs arrive on a valid/ready port that carries a left and a right word together. An accepted pair waits in a staging register until the next left slot begins. At that point both words move into the active registers, so a frame never mixes two different pairs. A new pair may be offered at any time. `s_ready` is high only while the staging register is empty. Once `s_valid` is raised, the source must hold it and the data stable until a cycle in which `s_ready` is also high. If no new pair has arrived by the start of a frame, the active words are sent again.

A level change on WS is seen at a rising SCK edge. It arms a load. On the next falling SCK edge, the shift register is parallel-loaded with the word for the new channel, so the MSB leaves one SCK period after WS changed. Each later falling edge shifts one bit out, and zeros fill in behind the LSB.

Top module: `stereo_serial_tx`

## Requirements
- R1: After reset, `sd_out` is 0 and `s_ready` is 1. Both active words are zero, and WS is taken to have been low (left) before the first sampled value.
- R2: A pair is accepted at a `clk` edge where `s_valid` and `s_ready` are both 1. While an accepted pair waits, `s_ready` stays 0 and an offered pair is not taken, so it cannot change what is sent.
- R3: A waiting pair becomes active at the next left-slot load. That frame's left and right words both come from that pair, and `s_ready` returns to 1 afterwards.
- R4: The word sent in a slot is chosen by the level of WS for that slot: WS = 0 sends the left word and WS = 1 sends the right word.
- R5: Words are sent MSB first, and bit i of the slot carries word bit DATA_W-1-i. The MSB is on `sd_out` at the first rising SCK edge after the rising edge at which a WS change was first seen, one SCK period after WS changed.
- R6: When a slot is longer than DATA_W bits, every bit after the LSB is 0.
- R7: When a slot is shorter than DATA_W bits, only the leading (most significant) bits are sent, and the next word starts with its own MSB.
- R8: When no new pair was accepted before a frame starts, that frame repeats the previous left and right words.
- R9: `sd_out` changes only after a falling SCK edge, so it is stable over every SCK high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sck_in | input | 1 | Bit clock from the external master |
| ws_in | input | 1 | Word select from the external master (0 left, 1 right) |
| s_valid | input | 1 | Sample pair valid |
| s_ready | output | 1 | Staging register empty, pair can be taken |
| s_left | input | DATA_W | Left sample, two's complement |
| s_right | input | DATA_W | Right sample, two's complement |
| sd_out | output | 1 | Serial data, changes after SCK falling edges |

## Verification
The assertions assume four things about the inputs:
- Each SCK high or low phase lasts longer than the synchronizer depth plus one system clock, so every edge is detected once.
- WS only changes while SCK is low.
- `s_valid` is held until accepted.
- The reset value of the load counter matches a shift register that holds no word.

The stimulus plays the master itself. It gives every SCK phase eight system clocks and changes WS together with a falling SCK edge. Its pair driver keeps `s_valid` and the data unchanged until a handshake completes. It also pauses SCK between frames to place handshakes at known points, which the synchronous edge detection tolerates.

// File: rtl/sstx_pkg.sv
package sstx_pkg;
  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;
endpackage

// File: rtl/sstx_edge_sync.sv
module sstx_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_in,
  input  logic ws_in,
  output logic sck_rise,
  output logic sck_fall,
  output logic ws_s
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sck_pipe;
  logic [SYNC_STAGES-1:0] ws_pipe;
  logic                   sck_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_pipe <= '0;
      ws_pipe  <= '0;
      sck_d    <= 1'b0;
    end else begin
      sck_pipe <= {sck_pipe[SYNC_STAGES-2:0], sck_in};
      ws_pipe  <= {ws_pipe[SYNC_STAGES-2:0], ws_in};
      sck_d    <= sck_pipe[TOP];
    end
  end

  assign sck_rise = sck_pipe[TOP] & ~sck_d;
  assign sck_fall = ~sck_pipe[TOP] & sck_d;
  assign ws_s     = ws_pipe[TOP];
endmodule

// File: rtl/sstx_sample_store.sv
module sstx_sample_store #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_left,
  input  logic [DATA_W-1:0] s_right,
  input  logic              take_left,
  output logic [DATA_W-1:0] left_word,
  output logic [DATA_W-1:0] right_word
);
  logic              full;
  logic [DATA_W-1:0] stage_l, stage_r;
  logic [DATA_W-1:0] act_l, act_r;
  logic              accept;

  assign s_ready = ~full;
  assign accept  = s_valid & ~full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full    <= 1'b0;
      stage_l <= '0;
      stage_r <= '0;
      act_l   <= '0;
      act_r   <= '0;
    end else if (take_left && full) begin
      act_l <= stage_l;
      act_r <= stage_r;
      full  <= 1'b0;
    end else if (accept) begin
      stage_l <= s_left;
      stage_r <= s_right;
      full    <= 1'b1;
    end
  end

  assign left_word  = full ? stage_l : act_l;
  assign right_word = act_r;
endmodule

// File: rtl/sstx_shifter.sv
module sstx_shifter
  import sstx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              ws_s,
  input  logic [DATA_W-1:0] left_word,
  input  logic [DATA_W-1:0] right_word,
  output logic              load_now,
  output logic              take_left,
  output logic              sd_out
);
  chan_e             ws_d;
  logic              load_pend;
  logic [DATA_W-1:0] shreg;

  assign load_now  = sck_fall & load_pend;
  assign take_left = load_now & (ws_d == CH_LEFT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ws_d      <= CH_LEFT;
      load_pend <= 1'b0;
      shreg     <= '0;
    end else begin
      if (sck_rise) begin
        ws_d <= chan_e'(ws_s);
        if (ws_s != ws_d) load_pend <= 1'b1;
      end
      if (sck_fall) begin
        if (load_pend) begin
          shreg     <= (ws_d == CH_LEFT) ? left_word : right_word;
          load_pend <= 1'b0;
        end else begin
          shreg <= {shreg[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  assign sd_out = shreg[DATA_W-1];
endmodule

// File: rtl/stereo_serial_tx.sv
module stereo_serial_tx #(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_in,
  input  logic              ws_in,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_left,
  input  logic [DATA_W-1:0] s_right,
  output logic              sd_out
);
  logic              sck_rise, sck_fall, ws_s;
  logic              load_now, take_left;
  logic [DATA_W-1:0] left_word, right_word;

  sstx_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck_in(sck_in), .ws_in(ws_in),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .ws_s(ws_s)
  );

  sstx_sample_store #(.DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_left(s_left), .s_right(s_right), .take_left(take_left),
    .left_word(left_word), .right_word(right_word)
  );

  sstx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .ws_s(ws_s), .left_word(left_word), .right_word(right_word),
    .load_now(load_now), .take_left(take_left), .sd_out(sd_out)
  );
endmodule

// File: rtl/stereo_serial_tx_chk.sv
module stereo_serial_tx_chk #(
  parameter int DATA_W = 16
) (
  input logic clk,
  input logic rst_n,
  input logic s_valid,
  input logic s_ready,
  input logic sd_out,
  input logic sck_fall,
  input logic load_now,
  input logic take_left
);
  localparam int CW = $clog2(DATA_W + 2) + 1;
  localparam logic [CW-1:0] LIM = CW'(DATA_W);

  logic [CW-1:0] falls_since_load;

  always_ff @(posedge clk) begin
    if (!rst_n) falls_since_load <= LIM + 1'b1;
    else if (load_now) falls_since_load <= 1;
    else if (sck_fall && falls_since_load <= LIM) falls_since_load <= falls_since_load + 1'b1;
  end

  AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready); // R2

  AST_LOAD_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (take_left && !s_ready) |=> s_ready); // R3

  AST_SD_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sd_out) |-> $past(sck_fall)); // R9

  AST_ZERO_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (falls_since_load > LIM) |-> !sd_out); // R6
endmodule

bind stereo_serial_tx stereo_serial_tx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .sd_out(sd_out), .sck_fall(sck_fall), .load_now(load_now),
  .take_left(take_left)
);

// File: tb/test_stereo_serial_tx.sv
module test_stereo_serial_tx;
  localparam int W    = 16;
  localparam int HALF = 8;

  typedef struct {
    logic         ch;
    logic [W-1:0] w;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sck = 1'b0;
  logic         ws = 1'b0;
  logic         s_valid = 1'b0;
  logic         s_ready;
  logic [W-1:0] s_left = '0;
  logic [W-1:0] s_right = '0;
  logic         sd_out;

  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;
  exp_t q[$];

  always #10 clk = ~clk;

  stereo_serial_tx #(.DATA_W(W)) i_stereo_serial_tx (
    .clk(clk), .rst_n(rst_n), .sck_in(sck), .ws_in(ws),
    .s_valid(s_valid), .s_ready(s_ready), .s_left(s_left),
    .s_right(s_right), .sd_out(sd_out)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic push_pair(input logic [W-1:0] l, input logic [W-1:0] r);
    @(negedge clk);
    s_valid = 1'b1; s_left = l; s_right = r;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic expect_frame(input logic [W-1:0] l, input logic [W-1:0] r, input string tag);
    q.push_back('{ch: 1'b0, w: l, tag: {tag, " left R4"}});
    q.push_back('{ch: 1'b1, w: r, tag: {tag, " right R4"}});
  endtask

  task automatic run_slot(input logic ch, input int slen);
    for (int i = 0; i < slen; i++) begin
      @(negedge clk);
      sck = 1'b0;
      if (i == 0) ws = ch;
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF - 1) @(negedge clk);
    end
  endtask

  // monitor: collect one slot of bits and compare with the scoreboard
  logic        last_ws = 1'b0;
  logic        open    = 1'b0;
  logic        cur_ch  = 1'b0;
  logic [63:0] rx      = '0;
  int          cnt     = 0;
  logic        rise_bit = 1'b0;

  task automatic finish_slot();
    exp_t        e;
    logic [63:0] expv;
    bit          ok;
    if (q.size() == 0) begin
      check(1'b0, "R3 slot with no expected word", 64'(cnt), 64'd0);
      return;
    end
    e = q.pop_front();
    expv = '0;
    for (int k = 0; k < cnt; k++) expv[k] = (k < W) ? e.w[W-1-k] : 1'b0;
    ok = (cur_ch == e.ch) && (rx == expv);
    check(ok, e.tag, rx, expv);
  endtask

  initial begin
    forever begin
      @(posedge sck);
      rise_bit = sd_out;
      if (ws != last_ws) begin
        if (open) begin
          rx[cnt] = sd_out;
          cnt++;
          finish_slot();
        end
        open = 1'b1; cur_ch = ws; rx = '0; cnt = 0;
        last_ws = ws;
      end else if (open) begin
        rx[cnt] = sd_out;
        cnt++;
      end
    end
  end

  initial begin
    forever begin
      @(negedge sck);
      if (rst_n) check(sd_out == rise_bit, "R9 sd stable over SCK high", 64'(sd_out), 64'(rise_bit));
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(s_ready == 1'b1, "R1 ready after reset", 64'(s_ready), 64'd1);
    check(sd_out == 1'b0, "R1 sd after reset", 64'(sd_out), 64'd0);

    // first right slot sends the reset right word
    q.push_back('{ch: 1'b1, w: '0, tag: "R1 reset right word"});
    run_slot(1'b1, 16);

    // frame A, slot equal to word length
    push_pair(16'h8001, 16'h7FFE);
    @(negedge clk);
    check(s_ready == 1'b0, "R2 ready low while pair waits", 64'(s_ready), 64'd0);
    expect_frame(16'h8001, 16'h7FFE, "R3 R5 frame A");
    run_slot(1'b0, 16);
    run_slot(1'b1, 16);

    // no new pair: repeat
    expect_frame(16'h8001, 16'h7FFE, "R8 repeat");
    run_slot(1'b0, 16);
    run_slot(1'b1, 16);

    // back-pressure: B waits, C offered and held off
    push_pair(16'h1234, 16'hFEDC);
    fork
      push_pair(16'hC0DE, 16'h0F0F);
    join_none
    repeat (20) @(negedge clk);
    check(s_ready == 1'b0 && s_valid == 1'b1, "R2 second pair held off", {s_ready, s_valid}, 64'b01);
    expect_frame(16'h1234, 16'hFEDC, "R2 R6 long slot");
    run_slot(1'b0, 20);
    run_slot(1'b1, 20);

    // C in a short slot
    expect_frame(16'hC0DE, 16'h0F0F, "R7 short slot");
    run_slot(1'b0, 12);
    run_slot(1'b1, 12);

    // mixed pattern
    push_pair(16'hA5C3, 16'h3C5A);
    expect_frame(16'hA5C3, 16'h3C5A, "R5 pattern");
    run_slot(1'b0, 16);
    run_slot(1'b1, 16);

    run_slot(1'b0, 4);
    repeat (4) @(negedge clk);
    check(q.size() == 0, "R3 all expected words sent", 64'(q.size()), 64'd0);
    check(s_ready == 1'b1, "R3 ready after last load", 64'(s_ready), 64'd1);

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule